// File: doc/BRIEF.md
# Presettable Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, with a parallel preset word, an active-low load strobe, an active-low count enable and an active-low terminal-count flag. The flag goes low while every count bit is one. The flag is taken straight from the count register, so it belongs to the same clock domain as the count.

A reload control feeds the terminal count back into the load path. With reload off, the counter runs freely and wraps from all ones to zero. With reload on, the counter takes the preset word at the edge where it would otherwise wrap, so it becomes a programmable divider with no logic outside it. For a divide ratio N from 2 to 256, the preset is 256 − N. The terminal-count flag is then a pulse one clock wide that repeats every N clocks.

Top module: `tc_reload_counter`

## Requirements
- R1: tc_no is 0 in exactly those cycles where count_o is all ones (0xFF at the default width), and is 1 otherwise.
- R2: When load_ni is 0 at a rising edge of clk_i, count_o takes preset_i at that edge, whatever the values of cnt_en_ni and reload_i.
- R3: When load_ni=1, cnt_en_ni=0 and reload_i=0, count_o increases by one at each rising edge and wraps from 0xFF to 0x00.
- R4: When load_ni=1, cnt_en_ni=0 and reload_i=1, count_o takes preset_i at an edge where count_o is 0xFF (tc_no=0), and increments by one at any other edge.
- R5: When load_ni=1 and cnt_en_ni=1, count_o keeps its value, including at all ones with reload_i=1.
- R6: While rst_ni is 0, count_o is 0 and tc_no is 1. Reset acts at once, without waiting for a clock edge.
- R7: In reload mode with preset P = 256 − N and N from 2 to 256, tc_no is 0 for exactly one clock every N clocks. P=0x00 gives N=256 and P=0xFE gives N=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| load_ni | input | 1 | Preset load strobe, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| reload_i | input | 1 | Reload on terminal count when high |
| preset_i | input | WIDTH | Preset word |
| count_o | output | WIDTH | Current count |
| tc_no | output | 1 | Terminal count, active low, low at all ones |

## Verification
The assertions check on every cycle that the next count follows the mode: a load, a hold, an increment with wrap, or a reload at terminal count. They also check that the count is zero during reset and that a terminal-count pulse in reload mode never lasts past one clock. Only the bench's scenarios can show the behaviour over longer spans. These cover the exact decode of all ones, a reset that arrives between edges, and the divide period for every ratio from 2 to 256, measured from the flag alone.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_decode.sv
module cnt_decode
  import cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    cnt_en_ni,
  input  logic    reload_i,
  input  logic    tc_n_i,
  output cnt_op_e op_o
);
  always_comb begin
    if (!load_ni)                 op_o = OP_LOAD;
    else if (cnt_en_ni)           op_o = OP_HOLD;
    else if (reload_i && !tc_n_i) op_o = OP_LOAD;  // terminal-count feedback
    else                          op_o = OP_INC;
  end
endmodule

// File: rtl/cnt_tc_detect.sv
module cnt_tc_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt_i,
  output logic             tc_no
);
  localparam int unsigned NIB    = 4;
  localparam int unsigned GROUPS = (WIDTH + NIB - 1) / NIB;
  localparam int unsigned PADW   = GROUPS * NIB;

  logic [PADW-1:0]   cnt_pad;
  logic [GROUPS-1:0] grp_ones;

  // unused upper bits are padded with ones so they never block the match
  always_comb begin
    cnt_pad = '1;
    cnt_pad[WIDTH-1:0] = cnt_i;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_ones[g] = &cnt_pad[g*NIB +: NIB];
  end

  assign tc_no = ~&grp_ones;
endmodule

// File: rtl/cnt_state.sv
module cnt_state
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             load_ni,
  input  logic             cnt_en_ni,
  input  logic             reload_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ONES = '1;

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (op_i)
      OP_LOAD: cnt_d = preset_i;
      OP_INC:  cnt_d = cnt_q + ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> cnt_q == $past(preset_i));  // R2
  AST_FREE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && !reload_i) |=> cnt_q == $past(cnt_q) + ONE);  // R3
  AST_TC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && reload_i && cnt_q == ONES) |=> cnt_q == $past(preset_i));  // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_ni) |=> $stable(cnt_q));  // R5
  AST_RST_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> cnt_q == '0);  // R6
endmodule

// File: rtl/tc_reload_counter.sv
module tc_reload_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             cnt_en_ni,
  input  logic             reload_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_no
);
  localparam logic [WIDTH-1:0] ONES = '1;

  cnt_op_e          op;
  logic [WIDTH-1:0] cnt;
  logic             tc_n;

  cnt_decode i_decode (
    .load_ni  (load_ni),
    .cnt_en_ni(cnt_en_ni),
    .reload_i (reload_i),
    .tc_n_i   (tc_n),
    .op_o     (op)
  );

  cnt_state #(.WIDTH(WIDTH)) i_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .preset_i (preset_i),
    .load_ni  (load_ni),
    .cnt_en_ni(cnt_en_ni),
    .reload_i (reload_i),
    .cnt_o    (cnt)
  );

  cnt_tc_detect #(.WIDTH(WIDTH)) i_tc (
    .cnt_i(cnt),
    .tc_no(tc_n)
  );

  assign count_o = cnt;
  assign tc_no   = tc_n;

  AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_no && load_ni && !cnt_en_ni && preset_i != ONES) |=> tc_no);  // R7
  AST_RST_TC_HIGH: assert property (@(posedge clk_i)
    !rst_ni |-> tc_no);  // R6
endmodule

// File: tb/test_tc_reload_counter.sv
module test_tc_reload_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_ni = 1'b1;
  logic       cnt_en_ni = 1'b1;
  logic       reload_i = 1'b0;
  logic [7:0] preset_i = 8'h00;
  logic [7:0] count_o;
  logic       tc_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] cnt;
    logic       tc_n;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model = 8'h00;

  always #10 clk_i = ~clk_i;

  tc_reload_counter i_tc_reload_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_ni  (load_ni),
    .cnt_en_ni(cnt_en_ni),
    .reload_i (reload_i),
    .preset_i (preset_i),
    .count_o  (count_o),
    .tc_no    (tc_no)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic ld_n, input logic ce_n, input logic rl,
                      input logic [7:0] p, input string tag);
    @(negedge clk_i);
    load_ni = ld_n; cnt_en_ni = ce_n; reload_i = rl; preset_i = p;
    @(posedge clk_i);
    if (!ld_n)                    model = p;
    else if (ce_n)                model = model;
    else if (rl && model == 8'hFF) model = p;
    else                          model = model + 8'd1;
    sb_q.push_back('{cnt: model, tc_n: (model != 8'hFF), tag: tag});
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(count_o == e.cnt, e.tag, "count", count_o, e.cnt);
      check(tc_no == e.tc_n, "R1", "tc_n", tc_no, e.tc_n);
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(count_o == 8'h00, "R6", "count in reset", count_o, 0);
    check(tc_no == 1'b1, "R6", "tc_n in reset", tc_no, 1);
    rst_ni = 1'b1;
    model = 8'h00;

    // R3 free run through the wrap
    for (int i = 0; i < 300; i++) step(1, 0, 0, 8'h33, "R3");

    // R2 load with enable off and reload on
    step(0, 1, 1, 8'h5A, "R2");
    // R5 hold
    for (int i = 0; i < 4; i++) step(1, 1, 0, 8'h11, "R5");
    step(0, 0, 1, 8'hFF, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 8'h22, "R5");
    // R3 wrap from all ones with reload off
    step(1, 0, 0, 8'h22, "R3");
    step(1, 0, 0, 8'h22, "R3");

    // R4 reload on terminal count
    step(0, 0, 0, 8'hFC, "R2");
    for (int i = 0; i < 12; i++) step(1, 0, 1, 8'hFC, "R4");
    // R2 load has priority while tc is low and reload is on
    step(0, 0, 1, 8'hFF, "R2");
    step(0, 0, 1, 8'h40, "R2");

    // R6 asynchronous reset between edges
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, "R3");
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    check(count_o == 8'h00, "R6", "count after async reset", count_o, 0);
    check(tc_no == 1'b1, "R6", "tc_n after async reset", tc_no, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model = 8'h00;

    // R7 divide ratio sweep, period measured from tc_no only
    for (int n = 2; n <= 256; n++) begin
      logic [7:0] p;
      int first, second, k;
      p = 8'((256 - n) & 8'hFF);
      step(0, 0, 1, p, "R7");
      first = -1; second = -1; k = 0;
      for (int c = 0; c < 2 * n + 2; c++) begin
        step(1, 0, 1, p, "R7");
        #1;
        k++;
        if (!tc_no) begin
          if (first < 0) first = k;
          else if (second < 0) second = k;
        end
      end
      check(second - first == n, "R7", "tc period", second - first, n);
    end

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule